// File: doc/BRIEF.md
# Descriptor Chain Walker

This block steers a data mover through a chain of transfer descriptors kept in memory. A start strobe hands it the byte address of the first node. It reads that node word by word over a memory read port and presents the whole node on a configuration bus. It then pulses the mover's go input and waits for the mover to report done. After that it follows the node's next pointer.

Each node is eight data words at consecutive word addresses. The words, by index, are:

| Index | Content |
|---|---|
| 0 | general config |
| 1 | read-port config |
| 2 | read address |
| 3 | write address |
| 4 | transfer size |
| 5 | next-node address |
| 6 | commands-done |
| 7 | control/status |

A next pointer of zero ends the chain. A last node that points back to the head makes the walk run until it is cancelled, which is how a cyclic buffer is served. An event pulse is raised once when the first node of a chain has been loaded, and once for every completed node.

The read port is two valid/ready channels. The request channel carries one word address. Once the walker raises request valid, it keeps valid and the address unchanged until ready is seen. The only exception is a cancel, which may withdraw a request that has not yet been accepted. At most one read is outstanding at a time. The response channel is accepted only while a read is outstanding, and the memory must hold response valid and data until ready is high. Control pins (start, cancel, go, done, event, busy) are plain levels and pulses.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, and whenever busy_o is low, the block issues no read request, no go pulse and no event, and busy_o is low after reset.
- R2: A start_i pulse while idle reads the eight words of the head node at head, head+4, …, head+28, in increasing order. A new request is issued only after the previous response has been accepted.
- R3: While rd_req_valid_o is high and rd_req_ready_i is low, with no cancel, the request stays valid and rd_req_addr_o stays unchanged in the next cycle.
- R4: One cycle after the eighth word is accepted, mover_go_o is high for exactly one cycle. During that cycle, word i of cfg_desc_o (bits i*DW and up) equals word i of the fetched node.
- R5: evt_o pulses for one cycle in the cycle after the first go pulse of a started chain, and in the cycle after each mover_done_i seen while waiting for the mover. A chain of N nodes ending in a zero pointer gives N+1 events.
- R6: mover_done_i has no effect while the block is idle or fetching: no event is raised.
- R7: When the completed node's next pointer (word 5) is zero, the block returns to idle and issues no further reads.
- R8: A non-zero next pointer starts a fetch at that address. The pointer is taken from the word read during the fetch, so a later memory change does not alter the walk.
- R9: A chain whose last node points back to the head repeats without stopping, and the first-load event is not raised again on later laps.
- R10: cancel_i in any state makes busy_o low in the next cycle, with no further go or event. A read already in flight is drained and its data discarded, and a new start then walks correctly.
- R11: start_i while busy is ignored: the walk in progress continues unchanged.
- R12: rd_rsp_ready_o is high only while a read request has been accepted and its response has not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken while idle |
| head_addr_i | input | AW | Byte address of the first node |
| cancel_i | input | 1 | Abort the walk and return to idle |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted by memory |
| rd_req_addr_o | output | AW | Byte address of the word to read |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_ready_o | output | 1 | Walker accepts read data |
| rd_rsp_data_i | input | DW | Read data word |
| cfg_desc_o | output | 8*DW | Loaded node, word i at bits i*DW and up |
| mover_go_o | output | 1 | One-cycle start pulse to the mover |
| mover_done_i | input | 1 | Mover completion pulse |
| evt_o | output | 1 | Load or completion event pulse |
| busy_o | output | 1 | High while a walk is in progress |

## Verification
The walk is driven with chains of one to seven nodes. These are run against request back-pressure on and off, response latencies of zero to three cycles, and mover delays from zero to five cycles. The go count, read count and event count separate a correct chain end from an early stop or an overrun, and the per-go word comparison catches wrong field capture or a wrong node order. A cyclic three-node chain tells a true loop, with one first-load event, from one that re-announces each lap. A cancel that lands while a read is outstanding, followed by an immediate restart, shows whether stale data leaks into the next node. Stray done pulses, a late memory overwrite of a next pointer, and a start while busy each check that something has no effect.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned IDX_NEXT   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_RUN,
    ST_NEXT
  } seq_state_e;
endpackage

// File: rtl/dcw_reader.sv
module dcw_reader #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  begin_i,
  input  logic [AW-1:0]         base_i,
  input  logic                  abort_i,
  output logic                  req_valid_o,
  input  logic                  req_ready_i,
  output logic [AW-1:0]         req_addr_o,
  input  logic                  rsp_valid_i,
  output logic                  rsp_ready_o,
  output logic                  word_valid_o,
  output logic [$clog2(NW)-1:0] word_idx_o,
  output logic                  last_o
);
  localparam int unsigned IW    = $clog2(NW);
  localparam int unsigned SHIFT = $clog2(DW / 8);

  logic          active_q, pend_q, drop_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic          req_fire, rsp_fire;

  assign req_valid_o  = active_q && !pend_q;
  assign req_addr_o   = base_q + (AW'(idx_q) << SHIFT);
  assign rsp_ready_o  = pend_q;
  assign req_fire     = req_valid_o && req_ready_i;
  assign rsp_fire     = rsp_valid_i && pend_q;
  assign word_valid_o = rsp_fire && !drop_q;
  assign word_idx_o   = idx_q;
  assign last_o       = word_valid_o && (idx_q == IW'(NW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      drop_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else begin
      if (rsp_fire)      pend_q <= 1'b0;
      else if (req_fire) pend_q <= 1'b1;

      if (abort_i && (req_fire || (pend_q && !rsp_fire))) drop_q <= 1'b1;
      else if (rsp_fire)                                 drop_q <= 1'b0;

      if (abort_i) begin
        active_q <= 1'b0;
      end else if (begin_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        base_q   <= base_i;
      end else if (word_valid_o) begin
        if (idx_q == IW'(NW - 1)) active_q <= 1'b0;
        else                      idx_q    <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcw_desc_regs.sv
module dcw_desc_regs #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [$clog2(NW)-1:0] idx_i,
  input  logic [DW-1:0]         data_i,
  output logic [NW*DW-1:0]      desc_o
);
  localparam int unsigned IW = $clog2(NW);

  for (genvar gi = 0; gi < NW; gi++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         word_q <= '0;
      else if (we_i && idx_i == IW'(gi))  word_q <= data_i;
    end
    assign desc_o[gi*DW +: DW] = word_q;
  end
endmodule

// File: rtl/dcw_seq.sv
module dcw_seq
  import dcw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] head_i,
  input  logic          cancel_i,
  input  logic          fetch_last_i,
  input  logic [AW-1:0] next_ptr_i,
  input  logic          mover_done_i,
  output logic          rd_begin_o,
  output logic [AW-1:0] rd_base_o,
  output logic          rd_abort_o,
  output logic          go_o,
  output logic          evt_o,
  output logic          busy_o
);
  seq_state_e state_q, state_d;
  logic       first_q, evt_q, evt_d;

  always_comb begin
    state_d    = state_q;
    rd_begin_o = 1'b0;
    rd_base_o  = head_i;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin
                  rd_begin_o = 1'b1;
                  state_d    = ST_FETCH;
                end
      ST_FETCH: if (fetch_last_i) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_RUN;
      ST_RUN:   if (mover_done_i) state_d = ST_NEXT;
      ST_NEXT:  if (next_ptr_i == '0) begin
                  state_d = ST_IDLE;
                end else begin
                  rd_begin_o = 1'b1;
                  rd_base_o  = next_ptr_i;
                  state_d    = ST_FETCH;
                end
      default:  state_d = ST_IDLE;
    endcase
    if (cancel_i) begin
      state_d    = ST_IDLE;
      rd_begin_o = 1'b0;
    end
  end

  assign evt_d = !cancel_i &&
                 (((state_q == ST_LOAD) && first_q) ||
                  ((state_q == ST_RUN) && mover_done_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= evt_d;
      if (cancel_i)                            first_q <= 1'b0;
      else if (state_q == ST_IDLE && start_i)  first_q <= 1'b1;
      else if (state_q == ST_LOAD)             first_q <= 1'b0;
    end
  end

  assign rd_abort_o = cancel_i;
  assign go_o       = (state_q == ST_LOAD);
  assign evt_o      = evt_q;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import dcw_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [AW-1:0]            head_addr_i,
  input  logic                     cancel_i,
  output logic                     rd_req_valid_o,
  input  logic                     rd_req_ready_i,
  output logic [AW-1:0]            rd_req_addr_o,
  input  logic                     rd_rsp_valid_i,
  output logic                     rd_rsp_ready_o,
  input  logic [DW-1:0]            rd_rsp_data_i,
  output logic [DESC_WORDS*DW-1:0] cfg_desc_o,
  output logic                     mover_go_o,
  input  logic                     mover_done_i,
  output logic                     evt_o,
  output logic                     busy_o
);
  localparam int unsigned NW = DESC_WORDS;
  localparam int unsigned IW = $clog2(NW);

  logic          rd_begin, rd_abort, word_valid, fetch_last;
  logic [AW-1:0] rd_base;
  logic [IW-1:0] word_idx;

  dcw_reader #(.AW(AW), .DW(DW), .NW(NW)) u_reader (
    .clk          (clk),
    .rst_n        (rst_n),
    .begin_i      (rd_begin),
    .base_i       (rd_base),
    .abort_i      (rd_abort),
    .req_valid_o  (rd_req_valid_o),
    .req_ready_i  (rd_req_ready_i),
    .req_addr_o   (rd_req_addr_o),
    .rsp_valid_i  (rd_rsp_valid_i),
    .rsp_ready_o  (rd_rsp_ready_o),
    .word_valid_o (word_valid),
    .word_idx_o   (word_idx),
    .last_o       (fetch_last)
  );

  dcw_desc_regs #(.DW(DW), .NW(NW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (word_valid),
    .idx_i  (word_idx),
    .data_i (rd_rsp_data_i),
    .desc_o (cfg_desc_o)
  );

  dcw_seq #(.AW(AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .head_i       (head_addr_i),
    .cancel_i     (cancel_i),
    .fetch_last_i (fetch_last),
    .next_ptr_i   (cfg_desc_o[IDX_NEXT*DW +: AW]),
    .mover_done_i (mover_done_i),
    .rd_begin_o   (rd_begin),
    .rd_base_o    (rd_base),
    .rd_abort_o   (rd_abort),
    .go_o         (mover_go_o),
    .evt_o        (evt_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cancel_i,
  input logic          rd_req_valid_o,
  input logic          rd_req_ready_i,
  input logic [AW-1:0] rd_req_addr_o,
  input logic          rd_rsp_ready_o,
  input logic          mover_go_o,
  input logic          mover_done_i,
  input logic          evt_o,
  input logic          busy_o
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_req_valid_o && !mover_go_o));

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_rsp_ready_o) |-> $past(rd_req_valid_o && rd_req_ready_i));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i && !cancel_i)
      |=> (rd_req_valid_o && $stable(rd_req_addr_o)));

  a_r4_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    mover_go_o |=> !mover_go_o);

  a_r5_evt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(mover_go_o || mover_done_i));

  a_r10_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> (!busy_o && !evt_o));

  a_r12_no_req_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready_o |-> !rd_req_valid_o);
endmodule

bind desc_chain_walker dcw_checker #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cancel_i       (cancel_i),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o),
  .rd_rsp_ready_o (rd_rsp_ready_o),
  .mover_go_o     (mover_go_o),
  .mover_done_i   (mover_done_i),
  .evt_o          (evt_o),
  .busy_o         (busy_o)
);

// File: tb/test_desc_chain_walker.sv
`timescale 1ns/1ps
module test_desc_chain_walker;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NW = 8;

  // vector: len[11:8], stall[7], rsp latency[6:4], mover delay[3:0]
  localparam logic [11:0] VEC [0:5] = '{12'h101, 12'h312, 12'h4A0,
                                        12'h285, 12'h531, 12'h793};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] head_addr_i = '0;
  logic          cancel_i = 1'b0;
  logic          rd_req_valid_o, rd_req_ready_i, rd_rsp_valid_i, rd_rsp_ready_o;
  logic [AW-1:0] rd_req_addr_o;
  logic [DW-1:0] rd_rsp_data_i;
  logic [NW*DW-1:0] cfg_desc_o;
  logic          mover_go_o, mover_done_i, evt_o, busy_o;

  desc_chain_walker #(.AW(AW), .DW(DW)) i_desc_chain_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_addr_i(head_addr_i),
    .cancel_i(cancel_i), .rd_req_valid_o(rd_req_valid_o),
    .rd_req_ready_i(rd_req_ready_i), .rd_req_addr_o(rd_req_addr_o),
    .rd_rsp_valid_i(rd_rsp_valid_i), .rd_rsp_ready_o(rd_rsp_ready_o),
    .rd_rsp_data_i(rd_rsp_data_i), .cfg_desc_o(cfg_desc_o),
    .mover_go_o(mover_go_o), .mover_done_i(mover_done_i), .evt_o(evt_o),
    .busy_o(busy_o));

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] node(input int k);
    return AW'(32 * (7 - k));
  endfunction

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int w);
    return 32'hC0DE0000 | DW'(a << 4) | DW'(w);
  endfunction

  // memory model
  logic [DW-1:0] mem [0:63];
  logic          stall_sel = 1'b0;
  int            lat_sel = 0;
  logic [7:0]    cyc = '0;
  logic          outst = 1'b0, rsp_v = 1'b0;
  logic [DW-1:0] rsp_d = '0;
  logic [AW-1:0] raddr = '0;
  int            lat_cnt = 0;
  int            rd_cnt = 0;

  assign rd_req_ready_i = !stall_sel || cyc[1];
  assign rd_rsp_valid_i = rsp_v;
  assign rd_rsp_data_i  = rsp_d;

  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (!rst_n) begin
      outst <= 1'b0;
      rsp_v <= 1'b0;
    end else begin
      if (rd_req_valid_o && rd_req_ready_i) begin
        outst   <= 1'b1;
        lat_cnt <= lat_sel;
        raddr   <= rd_req_addr_o;
        rd_cnt  <= rd_cnt + 1;
      end else if (outst && !rsp_v) begin
        if (lat_cnt == 0) begin
          rsp_v <= 1'b1;
          rsp_d <= mem[raddr[7:2]];
        end else begin
          lat_cnt <= lat_cnt - 1;
        end
      end
      if (rsp_v && rd_rsp_ready_o) begin
        rsp_v <= 1'b0;
        outst <= 1'b0;
      end
    end
  end

  // mover model
  int   mv_dly = 1;
  int   mv_cnt = 0;
  logic mv_act = 1'b0, mv_done = 1'b0;
  logic xdone = 1'b0;
  assign mover_done_i = mv_done | xdone;

  always @(posedge clk) begin
    mv_done <= 1'b0;
    if (!rst_n) begin
      mv_act <= 1'b0;
    end else if (mover_go_o) begin
      mv_act <= 1'b1;
      mv_cnt <= mv_dly;
    end else if (mv_act) begin
      if (mv_cnt == 0) begin
        mv_done <= 1'b1;
        mv_act  <= 1'b0;
      end else begin
        mv_cnt <= mv_cnt - 1;
      end
    end
  end

  // monitor
  int go_cnt = 0, evt_cnt = 0, cfg_bad = 0, evt_bad = 0, hold_bad = 0, rdy_bad = 0;
  int go_base = 0, run_len = 1;
  logic p_go = 1'b0, p_done = 1'b0, p_rv = 1'b0, p_rr = 1'b0, p_can = 1'b0;
  logic [AW-1:0] p_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mover_go_o) begin
        automatic logic [AW-1:0] ea = node((go_cnt - go_base) % run_len);
        for (int w = 0; w < NW; w++)
          if (w != 5 && cfg_desc_o[w*DW +: DW] != pat(ea, w)) begin
            cfg_bad = cfg_bad + 1;
            break;
          end
        go_cnt = go_cnt + 1;
      end
      if (evt_o) begin
        evt_cnt = evt_cnt + 1;
        if (!(p_go || p_done)) evt_bad = evt_bad + 1;
      end
      if (p_rv && !p_rr && !p_can && !(rd_req_valid_o && rd_req_addr_o == p_addr))
        hold_bad = hold_bad + 1;
      if (rd_rsp_ready_o && !outst) rdy_bad = rdy_bad + 1;
      p_go   = mover_go_o;
      p_done = mover_done_i;
      p_rv   = rd_req_valid_o;
      p_rr   = rd_req_ready_i;
      p_can  = cancel_i;
      p_addr = rd_req_addr_o;
    end
  end

  task automatic build_chain(input int len, input bit loop_back);
    for (int k = 0; k < len; k++) begin
      for (int w = 0; w < NW; w++) begin
        if (w == 5)
          mem[(node(k) >> 2) + w] = (k < len - 1) ? DW'(node(k + 1)) :
                                    (loop_back ? DW'(node(0)) : '0);
        else
          mem[(node(k) >> 2) + w] = pat(node(k), w);
      end
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    head_addr_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_go(input int n);
    for (int i = 0; i < 5000; i++) begin
      if (go_cnt - go_base >= n) break;
      @(negedge clk);
    end
  endtask

  int g0, e0, r0, c0;

  task automatic snap();
    go_base = go_cnt;
    g0 = go_cnt; e0 = evt_cnt; r0 = rd_cnt; c0 = cfg_bad;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy_o, "R1", "busy after reset", busy_o, 0);
    check(!rd_req_valid_o, "R1", "req valid after reset", rd_req_valid_o, 0);
    check(!mover_go_o && !evt_o, "R1", "go/evt after reset", mover_go_o | evt_o, 0);
    check(!rd_rsp_ready_o, "R12", "rsp ready after reset", rd_rsp_ready_o, 0);

    // table of vectors
    for (int v = 0; v < 6; v++) begin
      automatic int len = int'(VEC[v][11:8]);
      stall_sel = VEC[v][7];
      lat_sel   = int'(VEC[v][6:4]);
      mv_dly    = int'(VEC[v][3:0]);
      run_len   = len;
      build_chain(len, 1'b0);
      @(negedge clk);
      snap();
      pulse_start(node(0));
      check(busy_o, "R2", "busy after start", busy_o, 1);
      wait_idle();
      repeat (6) @(negedge clk);
      check(go_cnt - g0 == len, "R8", "go count", go_cnt - g0, len);
      check(rd_cnt - r0 == 8 * len, "R7", "read count", rd_cnt - r0, 8 * len);
      check(evt_cnt - e0 == len + 1, "R5", "event count", evt_cnt - e0, len + 1);
      check(cfg_bad == c0, "R4", "cfg words at go", cfg_bad - c0, 0);
    end
    check(evt_bad == 0, "R5", "event timing", evt_bad, 0);
    check(hold_bad == 0, "R3", "request hold under stall", hold_bad, 0);
    check(rdy_bad == 0, "R12", "rsp ready without outstanding read", rdy_bad, 0);

    // R6: done while idle
    snap();
    xdone = 1'b1; @(negedge clk); xdone = 1'b0;
    repeat (3) @(negedge clk);
    check(evt_cnt == e0 && !busy_o, "R6", "done while idle", evt_cnt - e0, 0);

    // R6: done while fetching
    stall_sel = 1'b0; lat_sel = 2; mv_dly = 1; run_len = 2;
    build_chain(2, 1'b0);
    snap();
    pulse_start(node(0));
    repeat (3) @(negedge clk);
    xdone = 1'b1; @(negedge clk); xdone = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    check(evt_cnt - e0 == 3, "R6", "events with stray done in fetch", evt_cnt - e0, 3);
    check(go_cnt - g0 == 2, "R6", "go count with stray done", go_cnt - g0, 2);

    // R8: next pointer captured during fetch
    lat_sel = 0; mv_dly = 20; run_len = 2;
    build_chain(2, 1'b0);
    snap();
    pulse_start(node(0));
    wait_go(1);
    mem[(node(0) >> 2) + 5] = '0;
    wait_idle();
    repeat (4) @(negedge clk);
    check(go_cnt - g0 == 2, "R8", "walk after memory overwrite", go_cnt - g0, 2);
    check(cfg_bad == c0, "R8", "cfg of second node", cfg_bad - c0, 0);

    // R11: start while busy ignored
    mv_dly = 10; run_len = 2;
    build_chain(2, 1'b0);
    snap();
    pulse_start(node(0));
    wait_go(1);
    pulse_start(32'h20);
    wait_idle();
    repeat (4) @(negedge clk);
    check(go_cnt - g0 == 2, "R11", "go count", go_cnt - g0, 2);
    check(cfg_bad == c0 && rd_cnt - r0 == 16, "R11", "reads", rd_cnt - r0, 16);

    // R9: cyclic chain, then R10 cancel
    mv_dly = 1; lat_sel = 1; run_len = 3;
    build_chain(3, 1'b1);
    snap();
    pulse_start(node(0));
    wait_go(7);
    check(go_cnt - g0 >= 7, "R9", "laps", go_cnt - g0, 7);
    check(evt_cnt - e0 == go_cnt - g0, "R9", "single load event", evt_cnt - e0, go_cnt - g0);
    check(cfg_bad == c0, "R9", "node order", cfg_bad - c0, 0);
    cancel_i = 1'b1; @(negedge clk); cancel_i = 1'b0;
    check(!busy_o, "R10", "busy after cancel", busy_o, 0);
    g0 = go_cnt; e0 = evt_cnt;
    repeat (60) @(negedge clk);
    check(go_cnt == g0 && evt_cnt == e0, "R10", "activity after cancel", go_cnt - g0, 0);

    // R10: cancel with a read in flight, then restart
    lat_sel = 3; run_len = 1;
    build_chain(2, 1'b0);
    pulse_start(node(0));
    for (int i = 0; i < 50; i++) begin
      if (rd_rsp_ready_o) break;
      @(negedge clk);
    end
    cancel_i = 1'b1; @(negedge clk); cancel_i = 1'b0;
    check(!busy_o, "R10", "busy after mid-fetch cancel", busy_o, 0);
    build_chain(1, 1'b0);
    snap();
    pulse_start(node(0));
    wait_idle();
    repeat (4) @(negedge clk);
    check(go_cnt - g0 == 1, "R10", "restart go count", go_cnt - g0, 1);
    check(cfg_bad == c0, "R10", "stale data discarded", cfg_bad - c0, 0);
    check(evt_cnt - e0 == 2, "R10", "restart events", evt_cnt - e0, 2);
    check(rdy_bad == 0, "R12", "rsp ready only while outstanding", rdy_bad, 0);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    summary();
    $finish;
  end
endmodule